// File: doc/BRIEF.md
# Two-Wire Bus Target with Busy Refusal

This block is the target (slave) side of a two-wire serial bus. It oversamples the clock line and the data line with a fast system clock, and it finds START, repeated START and STOP conditions. It collects the first byte of each transfer and compares it with a fixed four-bit identifier and a three-bit address, which comes from an address register outside the block. On a match it acknowledges. After that it either forwards each received byte to a register-file port, or it fetches bytes from that port and shifts them out onto the bus.

The block never drives the data line high. It only pulls it low through an active-low output enable, and an external pull-up provides the high level. A busy input marks that a non-volatile write is in progress. While busy is high, the block refuses transfers with NACK and forwards nothing. A read ends when the host answers a byte with NACK. The block then releases the line so that the host can issue STOP.

Top module: `twi_target`

## Requirements
- R1: While reset is held, `sda_oe_n` is 1 (line released) and both `wr_stb_o` and `rd_stb_o` are 0.
- R2: The address byte is received most significant bit first, with `1011` in bits 7..4, A2..A0 in bits 3..1 and the direction bit in bit 0. When bits 7..4 equal `1011`, bits 3..1 equal `dev_addr_i` and `busy_i` is low, the block acknowledges by holding SDA low during the high phase of the ninth clock.
- R3: When either the identifier or the address bits do not match, the block does not acknowledge, forwards or fetches nothing and keeps SDA released for the rest of the transfer.
- R4: With direction bit 0, each following 8-bit data byte (MSB first) is presented on `wr_data_o` during a one-cycle `wr_stb_o` pulse and is acknowledged. Any number of bytes may follow in one transfer.
- R5: With direction bit 1, the block takes `rd_data_i` on the clock edge where `rd_stb_o` is high: once at the address ACK and again after every host ACK. It drives the byte MSB first, pulling SDA low for 0 bits.
- R6: A host NACK after a read byte ends the read. SDA stays released and no further fetch occurs until the next START.
- R7: While `busy_i` is high, an addressed transfer gets NACK at the address byte. A write data byte that ends while busy is high gets NACK, is not forwarded and ends the transfer. Normal answers resume once busy is low.
- R8: A repeated START at any point restarts address reception, and the new direction bit takes effect.
- R9: A STOP returns the block to idle with SDA released, and bytes clocked before the next START are ignored.
- R10: The block changes `sda_oe_n` only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_n | output | 1 | 0 pulls the data line low, 1 releases it |
| dev_addr_i | input | 3 | Address bits A2..A0 from the address register |
| busy_i | input | 1 | High while a non-volatile write is in progress |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write byte |
| wr_data_o | output | 8 | Received write byte, valid with `wr_stb_o` |
| rd_stb_o | output | 1 | One-cycle fetch pulse, `rd_data_i` is taken on this edge |
| rd_data_i | input | 8 | Byte to transmit on the next read |

## Verification
If the sequencing state is wrong, the acknowledge slot shows it first. A lost bit count or a stuck state moves the ACK, drops it or makes it appear one bit early. The host sees this at the ninth clock of the same byte. A wrong direction or a wrong fetch shows up as a wrong read byte, or a wrong number of `rd_stb_o` pulses, within the next byte time. A failure to release after NACK, STOP or mismatch shows up as SDA held low, or as an unexpected ACK, on the very next bit the host clocks.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } twi_st_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= synced;
    end
  end

  // line 0 is the clock, line 1 the data
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev_q[0];
  assign scl_fall  = ~synced[0] & prev_q[0];
  assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/twi_bitctl.sv
module twi_bitctl #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic              cnt_clr,
  input  logic              cnt_en,
  input  logic              tx_load,
  input  logic              tx_shift,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_bit,
  output logic              byte_done
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              take_bit;

  assign byte_done = (cnt_q == CNT_W'(DATA_W));
  assign take_bit  = cnt_en & scl_rise & ~byte_done;

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (take_bit) begin
      cnt_d = cnt_q + CNT_W'(1);
      rx_d  = {rx_q[DATA_W-2:0], sda_s};
    end
  end

  always_comb begin
    tx_d = tx_q;
    if (tx_load) begin
      tx_d = tx_data;
    end else if (tx_shift) begin
      tx_d = {tx_q[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '1;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign rx_byte = rx_q;
  assign tx_bit  = tx_q[DATA_W-1];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_W)); // R2
endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
  import twi_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              ID_W   = 4,
  parameter int              ADDR_W = 3,
  parameter logic [ID_W-1:0] DEV_ID = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              byte_done,
  input  logic              tx_bit,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              cnt_clr,
  output logic              cnt_en,
  output logic              tx_load,
  output logic              tx_shift,
  output logic              wr_stb_o,
  output logic              rd_stb_o,
  output logic              drive_low_o
);
  twi_st_e st_q, st_d;
  logic    pull_q, pull_d;
  logic    rw_q, rw_d;
  logic    mack_q, mack_d;
  logic    addr_hit;

  assign addr_hit = (rx_byte[DATA_W-1 -: ID_W] == DEV_ID) &&
                    (rx_byte[ADDR_W:1] == dev_addr_i);

  always_comb begin
    st_d     = st_q;
    pull_d   = pull_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    cnt_clr  = 1'b0;
    cnt_en   = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    wr_stb_o = 1'b0;
    rd_stb_o = 1'b0;
    if (stop_det) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else if (start_det) begin
      st_d    = ST_ADDR;
      pull_d  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE, ST_SKIP: begin
          st_d = st_q;
        end
        ST_ADDR: begin
          cnt_en = 1'b1;
          if (scl_fall && byte_done) begin
            if (addr_hit) begin
              st_d   = ST_AACK;
              pull_d = ~busy_i;
              rw_d   = rx_byte[0];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            if (!pull_q) begin
              st_d = ST_SKIP;
            end else if (rw_q) begin
              st_d     = ST_RDAT;
              tx_load  = 1'b1;
              rd_stb_o = 1'b1;
              cnt_clr  = 1'b1;
            end else begin
              st_d    = ST_WDAT;
              cnt_clr = 1'b1;
            end
          end
        end
        ST_WDAT: begin
          cnt_en = 1'b1;
          if (scl_fall && byte_done) begin
            st_d     = ST_WACK;
            pull_d   = ~busy_i;
            wr_stb_o = ~busy_i;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_clr = 1'b1;
            st_d    = pull_q ? ST_WDAT : ST_SKIP;
          end
        end
        ST_RDAT: begin
          cnt_en = 1'b1;
          if (scl_fall) begin
            if (byte_done) begin
              st_d = ST_RACK;
            end else begin
              tx_shift = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
          end
          if (scl_fall) begin
            if (!mack_q) begin
              st_d     = ST_RDAT;
              tx_load  = 1'b1;
              rd_stb_o = 1'b1;
              cnt_clr  = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      pull_q <= pull_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
    end
  end

  assign drive_low_o = pull_q | ((st_q == ST_RDAT) & ~tx_bit);

  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SKIP) || (st_q == ST_IDLE)) |-> !drive_low_o); // R3
  AST_FETCH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> (st_q == ST_RDAT)); // R5
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> drive_low_o); // R4
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_AACK) && ($past(st_q) != ST_AACK) && $past(busy_i)) |-> !pull_q); // R7
endmodule

// File: rtl/twi_target.sv
module twi_target #(
  parameter int         DATA_W      = 8,
  parameter int         ID_W        = 4,
  parameter int         ADDR_W      = 3,
  parameter logic [3:0] DEV_ID      = 4'b1011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_n,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              busy_i,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              cnt_clr, cnt_en, tx_load, tx_shift;
  logic [DATA_W-1:0] rx_byte;
  logic              tx_bit, byte_done, drive_low;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_bitctl #(.DATA_W(DATA_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .sda_s     (sda_s),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .tx_load   (tx_load),
    .tx_shift  (tx_shift),
    .tx_data   (rd_data_i),
    .rx_byte   (rx_byte),
    .tx_bit    (tx_bit),
    .byte_done (byte_done)
  );

  twi_fsm #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W),
    .DEV_ID (DEV_ID[ID_W-1:0])
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_s       (sda_s),
    .rx_byte     (rx_byte),
    .byte_done   (byte_done),
    .tx_bit      (tx_bit),
    .busy_i      (busy_i),
    .dev_addr_i  (dev_addr_i),
    .cnt_clr     (cnt_clr),
    .cnt_en      (cnt_en),
    .tx_load     (tx_load),
    .tx_shift    (tx_shift),
    .wr_stb_o    (wr_stb_o),
    .rd_stb_o    (rd_stb_o),
    .drive_low_o (drive_low)
  );

  assign sda_oe_n  = ~drive_low;
  assign wr_data_o = rx_byte;

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sda_oe_n) |-> $past(scl_fall | start_det | stop_det)); // R10
endmodule

// File: tb/twi_target_tb_top.sv
module twi_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int NVEC       = 8;

  // dev[22:20] busy[19] addr[18:11] data[10:3] exp_addr_ack[2] exp_data_ack[1] exp_fwd[0]
  localparam logic [22:0] VECS [0:NVEC-1] = '{
    {3'd5, 1'b0, 8'hBA, 8'h3C, 3'b111},
    {3'd5, 1'b0, 8'hB8, 8'h55, 3'b000},
    {3'd0, 1'b0, 8'hB0, 8'h00, 3'b111},
    {3'd7, 1'b0, 8'hBE, 8'hFF, 3'b111},
    {3'd7, 1'b0, 8'h3E, 8'h12, 3'b000},
    {3'd2, 1'b1, 8'hB4, 8'h99, 3'b000},
    {3'd2, 1'b0, 8'hB4, 8'h81, 3'b111},
    {3'd3, 1'b0, 8'hA6, 8'h44, 3'b000}
  };

  logic       clk, rst_n, scl_m, sda_m, sda_line, sda_oe_n;
  logic [2:0] dev_addr;
  logic       busy, wr_stb, rd_stb;
  logic [7:0] wr_data, rd_data;
  int         n_chk, n_fail, wr_cnt, rd_cnt, glitch;
  logic [7:0] wr_last;
  logic       scl_prev, oe_prev;

  assign sda_line = sda_m & sda_oe_n;
  assign rd_data  = 8'hC3 + 8'(rd_cnt * 17);

  twi_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_n   (sda_oe_n),
    .dev_addr_i (dev_addr),
    .busy_i     (busy),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb),
    .rd_data_i  (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (wr_stb) begin
      wr_cnt  = wr_cnt + 1;
      wr_last = wr_data;
    end
    if (rd_stb) rd_cnt = rd_cnt + 1;
    if (scl_m && scl_prev && (sda_oe_n !== oe_prev)) glitch = glitch + 1;
    scl_prev = scl_m;
    oe_prev  = sda_oe_n;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b;    tick(4);
    scl_m = 1'b1; tick(4);
    s = sda_line; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    acked = ~s;
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~host_ack, s);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL WDOG actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         w0, r0;
    n_chk = 0; n_fail = 0; wr_cnt = 0; rd_cnt = 0; glitch = 0;
    wr_last = 8'h00; scl_prev = 1'b1; oe_prev = 1'b1;
    scl_m = 1'b1; sda_m = 1'b1; dev_addr = 3'd5; busy = 1'b0;
    rst_n = 1'b0;
    tick(5);
    chk("R1 oe", 32'(sda_oe_n), 32'd1);
    chk("R1 wr_stb", 32'(wr_stb), 32'd0);
    chk("R1 rd_stb", 32'(rd_stb), 32'd0);
    rst_n = 1'b1;
    tick(10);

    // table walk: one address byte and one data byte each
    for (int v = 0; v < NVEC; v++) begin
      logic [22:0] e;
      string tg;
      e = VECS[v];
      dev_addr = e[22:20];
      busy     = e[19];
      tg = e[2] ? "R2" : (e[19] ? "R7" : "R3");
      w0 = wr_cnt;
      bus_start();
      put_byte(e[18:11], ack);
      chk(tg, 32'(ack), 32'(e[2]));
      put_byte(e[10:3], ack);
      chk(e[1] ? "R4 data ack" : tg, 32'(ack), 32'(e[1]));
      chk("R4 fwd count", 32'(wr_cnt - w0), 32'(e[0]));
      if (e[0]) chk("R4 fwd data", 32'(wr_last), 32'(e[10:3]));
      bus_stop();
      chk("R9 released", 32'(sda_oe_n), 32'd1);
      busy = 1'b0;
    end

    // multi-byte write, busy rises before the third byte
    dev_addr = 3'd5;
    w0 = wr_cnt;
    bus_start();
    put_byte(8'hBA, ack); chk("R2", 32'(ack), 32'd1);
    put_byte(8'h01, ack); chk("R4 b1", 32'(ack), 32'd1);
    put_byte(8'h02, ack); chk("R4 b2", 32'(ack), 32'd1);
    busy = 1'b1;
    put_byte(8'h03, ack); chk("R7 busy data", 32'(ack), 32'd0);
    busy = 1'b0;
    put_byte(8'h04, ack); chk("R7 after refusal", 32'(ack), 32'd0);
    bus_stop();
    chk("R4 count", 32'(wr_cnt - w0), 32'd2);
    chk("R7 not fwd", 32'(wr_last), 32'h02);

    // read of three bytes, host NACKs the last
    r0 = rd_cnt;
    bus_start();
    put_byte(8'hBB, ack); chk("R2 read addr", 32'(ack), 32'd1);
    get_byte(1'b1, d); chk("R5 rd0", 32'(d), 32'(8'(8'hC3 + 8'(r0 * 17))));
    get_byte(1'b1, d); chk("R5 rd1", 32'(d), 32'(8'(8'hC3 + 8'((r0 + 1) * 17))));
    get_byte(1'b0, d); chk("R5 rd2", 32'(d), 32'(8'(8'hC3 + 8'((r0 + 2) * 17))));
    chk("R6 released", 32'(sda_oe_n), 32'd1);
    get_byte(1'b0, d); chk("R6 idle line", 32'(d), 32'hFF);
    chk("R6 fetches", 32'(rd_cnt - r0), 32'd3);
    bus_stop();

    // write then repeated START into a read
    bus_start();
    put_byte(8'hBA, ack); chk("R2", 32'(ack), 32'd1);
    put_byte(8'h11, ack); chk("R4", 32'(wr_last), 32'h11);
    r0 = rd_cnt;
    bus_start();
    put_byte(8'hBB, ack); chk("R8 readdress", 32'(ack), 32'd1);
    get_byte(1'b0, d); chk("R8 read", 32'(d), 32'(8'(8'hC3 + 8'(r0 * 17))));
    bus_stop();

    // busy read request
    busy = 1'b1;
    r0 = rd_cnt;
    bus_start();
    put_byte(8'hBB, ack); chk("R7 busy read", 32'(ack), 32'd0);
    get_byte(1'b0, d); chk("R7 no drive", 32'(d), 32'hFF);
    chk("R7 no fetch", 32'(rd_cnt - r0), 32'd0);
    bus_stop();
    busy = 1'b0;

    // STOP mid-transfer, then bytes with no START
    w0 = wr_cnt;
    bus_start();
    put_byte(8'hBA, ack); chk("R2", 32'(ack), 32'd1);
    bus_stop();
    scl_m = 1'b0; tick(4);
    put_byte(8'hBA, ack); chk("R9 no start addr", 32'(ack), 32'd0);
    put_byte(8'h66, ack); chk("R9 no start data", 32'(ack), 32'd0);
    chk("R9 no fwd", 32'(wr_cnt - w0), 32'd0);
    bus_stop();

    chk("R10 sda edges", 32'(glitch), 32'd0);
    summary();
    $finish;
  end
endmodule